// File: doc/BRIEF.md
# Circular Sample-Memory Address Generator

This block forms the byte address that a 128-step audio effects program uses when it reads from or writes to its external sample memory. Each access names a base word from the program's address table. An optional 12-bit offset and a +1 step can be added to that word. The address then either wraps inside a circular delay region or, in table mode, indexes a flat 64 K-word area. The word address is turned into a byte address, moved by a programmable byte base, and clipped to the size of the attached memory.

The circular region is walked by a frame counter. The counter steps down by one at the end of every sample frame and reloads with the region length when it would reach zero, so the same program offset reaches a different word each frame. Accesses are legal only on odd steps. The address is registered and shown for one cycle with a strobe and a write flag, together with the index of the four-entry return slot that the fetched data must land in.

Top module: `rbag_top`

## Requirements
- R1: The starting word is `base_word`. When `add_adrs` is 1, the low 12 bits of `adrs_val` are added to it (bits 15:12 are ignored). When `next_word` is 1, one more is added.
- R2: When `table_mode` is 0, the current `frame_ctr` is added to the word and the sum is ANDed with the ring-length mask, so the word wraps inside the circular region.
- R3: When `table_mode` is 1, the frame counter is not added and the word is cut to its low 16 bits.
- R4: The byte address is the word times two plus the byte base. It is truncated to 21 bits when MEM_MIB is 2 and to 23 bits when MEM_MIB is 8. Any other MEM_MIB stops elaboration.
- R5: A request is accepted only when `step_idx` bit 0 is 1. A request on an even step gives no strobe and leaves `mem_addr` unchanged.
- R6: An accepted request raises `mem_valid` for exactly the one cycle after it, with the new `mem_addr`. `mem_we` is 1 when `req_wr` was set, so a request with both `req_rd` and `req_wr` is a write. `mem_we` is 0 whenever `mem_valid` is 0.
- R7: With each strobe, `rd_slot` equals (`step_idx` + 2) mod 4 of the accepted request.
- R8: A `frame_end` pulse lowers `frame_ctr` by one. When the count is 1, it reloads with the ring mask + 1 instead, so it is never 0.
- R9: After reset, the ring mask is 0x7FFF, the byte base is 0, `frame_ctr` is 1, and `mem_valid`, `mem_we` and `mem_addr` are 0.
- R10: `cfg_load` replaces the ring mask and byte base with `cfg_mask` and `cfg_base`, and does not change `frame_ctr`. Without `frame_end`, `frame_ctr` holds.
- R11: A request in the same cycle as `frame_end` or `cfg_load` uses the counter, mask and base from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load new ring mask and byte base |
| cfg_mask | input | 16 | Ring-length mask (length - 1) |
| cfg_base | input | 21 | Byte base of the region (23 when MEM_MIB is 8) |
| frame_end | input | 1 | End-of-frame pulse that steps the counter |
| step_idx | input | 7 | Program step of the request |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request |
| base_word | input | 16 | Selected base word from the address table |
| adrs_val | input | 16 | Computed address register; bits 11:0 are used |
| add_adrs | input | 1 | Add the offset register |
| next_word | input | 1 | Add one word |
| table_mode | input | 1 | Flat table addressing, no wrap |
| mem_addr | output | 21 | Registered byte address (23 when MEM_MIB is 8) |
| mem_valid | output | 1 | One-cycle access strobe |
| mem_we | output | 1 | Access is a write |
| rd_slot | output | 2 | Return-data slot for this access |
| frame_ctr | output | 17 | Current frame counter |

## Verification
A wrong frame count shows at `frame_ctr` one cycle after the `frame_end` that caused it. It also moves every later non-table address by the same word offset, which makes a ring wrap that is off by one easy to see. A stale mask or base shows on the first strobe after `cfg_load`. A strobe or address change on an even step shows in the cycle right after the request. Random mask sizes and counter phases are mixed with directed wrap, table and truncation cases. Every cycle is compared with a model held in the bench.

// File: rtl/rbag_pkg.sv
package rbag_pkg;
   // Default geometry shared by the block and its checker.
   localparam int WORD_W      = 16;   // address-table word width
   localparam int ADRS_W      = 16;   // offset register width
   localparam int OFS_W       = 12;   // bits of the offset register that are added
   localparam int MASK_W      = 16;   // ring-length mask width
   localparam int TABLE_W     = 16;   // word width kept in table mode
   localparam int STEPS       = 128;  // program length
   localparam int SLOTS       = 4;    // return-data slots
   localparam int READ_LEAD   = 2;    // slot lead of a read over its step
   localparam logic [MASK_W-1:0] RESET_MASK = 16'h7FFF;

   // One access request as seen by the address datapath.
   typedef struct packed {
      logic rd;
      logic wr;
      logic add_ofs;
      logic plus_one;
      logic flat;
   } acc_req_t;
endpackage

// File: rtl/rbag_cfg_regs.sv
module rbag_cfg_regs #(
   parameter int MASK_W = 16,
   parameter int BASE_W = 21,
   parameter logic [MASK_W-1:0] RESET_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [MASK_W-1:0] mask_in,
   input  logic [BASE_W-1:0] base_in,
   output logic [MASK_W-1:0] mask_q,
   output logic [BASE_W-1:0] base_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= RESET_MASK;
         base_q <= '0;
      end else if (load) begin
         mask_q <= mask_in;
         base_q <= base_in;
      end
   end
endmodule

// File: rtl/rbag_frame_ctr.sv
module rbag_frame_ctr #(
   parameter int MASK_W = 16,
   localparam int CNT_W = MASK_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [MASK_W-1:0] mask,
   output logic [CNT_W-1:0]  count
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             at_last;
   logic [CNT_W-1:0] reload_val;
   logic [CNT_W-1:0] next_count;

   always_comb begin
      at_last    = (count == ONE);
      reload_val = CNT_W'(mask) + ONE;
      next_count = at_last ? reload_val : (count - ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= ONE;
      else if (tick)
         count <= next_count;
   end
endmodule

// File: rtl/rbag_addr_calc.sv
module rbag_addr_calc #(
   parameter int WORD_W  = 16,
   parameter int ADRS_W  = 16,
   parameter int OFS_W   = 12,
   parameter int MASK_W  = 16,
   parameter int TABLE_W = 16,
   parameter int ADDR_W  = 21,
   localparam int CNT_W  = MASK_W + 1
) (
   input  logic [WORD_W-1:0] base_word,
   input  logic [ADRS_W-1:0] adrs_val,
   input  rbag_pkg::acc_req_t req,
   input  logic [CNT_W-1:0]  count,
   input  logic [MASK_W-1:0] mask,
   input  logic [ADDR_W-1:0] byte_base,
   output logic [ADDR_W-1:0] byte_addr
);
   localparam int WIDEST = (WORD_W > CNT_W) ? WORD_W : CNT_W;
   localparam int SUM_W  = WIDEST + 2;
   localparam int BSUM_W = (SUM_W + 1 > ADDR_W) ? SUM_W + 1 : ADDR_W;
   localparam logic [SUM_W-1:0] FLAT_MASK = SUM_W'({TABLE_W{1'b1}});

   logic [SUM_W-1:0]  ofs_term;
   logic [SUM_W-1:0]  word_raw;
   logic [SUM_W-1:0]  word_ring;
   logic [SUM_W-1:0]  word_flat;
   logic [SUM_W-1:0]  word_sel;
   logic [BSUM_W-1:0] byte_sum;

   always_comb begin
      ofs_term  = req.add_ofs ? SUM_W'(adrs_val[OFS_W-1:0]) : '0;
      word_raw  = SUM_W'(base_word) + ofs_term + SUM_W'(req.plus_one);
      word_ring = (word_raw + SUM_W'(count)) & SUM_W'(mask);
      word_flat = word_raw & FLAT_MASK;
      word_sel  = req.flat ? word_flat : word_ring;
      byte_sum  = (BSUM_W'(word_sel) << 1) + BSUM_W'(byte_base);
      byte_addr = byte_sum[ADDR_W-1:0];
   end
endmodule

// File: rtl/rbag_top.sv
module rbag_top #(
   parameter int MEM_MIB = 2,
   parameter int MASK_W  = rbag_pkg::MASK_W,
   parameter int WORD_W  = rbag_pkg::WORD_W,
   parameter int ADRS_W  = rbag_pkg::ADRS_W,
   parameter int STEPS   = rbag_pkg::STEPS,
   parameter int SLOTS   = rbag_pkg::SLOTS,
   localparam int ADDR_W = (MEM_MIB == 8) ? 23 : 21,
   localparam int CNT_W  = MASK_W + 1,
   localparam int STEP_W = $clog2(STEPS),
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic [MASK_W-1:0] cfg_mask,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic              frame_end,
   input  logic [STEP_W-1:0] step_idx,
   input  logic              req_rd,
   input  logic              req_wr,
   input  logic [WORD_W-1:0] base_word,
   input  logic [ADRS_W-1:0] adrs_val,
   input  logic              add_adrs,
   input  logic              next_word,
   input  logic              table_mode,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_valid,
   output logic              mem_we,
   output logic [SLOT_W-1:0] rd_slot,
   output logic [CNT_W-1:0]  frame_ctr
);
   import rbag_pkg::*;

   // Only the two supported memory sizes may be built.
   generate
      if (MEM_MIB != 2 && MEM_MIB != 8) begin : g_bad_size
         $error("rbag_top: MEM_MIB must be 2 or 8");
      end
      if (SLOTS != (1 << SLOT_W)) begin : g_bad_slots
         $error("rbag_top: SLOTS must be a power of two");
      end
      if (STEPS != (1 << STEP_W)) begin : g_bad_steps
         $error("rbag_top: STEPS must be a power of two");
      end
   endgenerate

   logic [MASK_W-1:0] mask_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] addr_d;
   acc_req_t          req;
   logic              accept;
   logic [SLOT_W-1:0] slot_d;

   assign req.rd       = req_rd;
   assign req.wr       = req_wr;
   assign req.add_ofs  = add_adrs;
   assign req.plus_one = next_word;
   assign req.flat     = table_mode;

   assign accept = (req_rd | req_wr) & step_idx[0];
   assign slot_d = step_idx[SLOT_W-1:0] + SLOT_W'(READ_LEAD);

   rbag_cfg_regs #(
      .MASK_W     (MASK_W),
      .BASE_W     (ADDR_W),
      .RESET_MASK (MASK_W'(RESET_MASK))
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cfg_load),
      .mask_in (cfg_mask),
      .base_in (cfg_base),
      .mask_q  (mask_q),
      .base_q  (base_q)
   );

   rbag_frame_ctr #(
      .MASK_W (MASK_W)
   ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (frame_end),
      .mask  (mask_q),
      .count (frame_ctr)
   );

   rbag_addr_calc #(
      .WORD_W  (WORD_W),
      .ADRS_W  (ADRS_W),
      .OFS_W   (OFS_W),
      .MASK_W  (MASK_W),
      .TABLE_W (TABLE_W),
      .ADDR_W  (ADDR_W)
   ) u_calc (
      .base_word (base_word),
      .adrs_val  (adrs_val),
      .req       (req),
      .count     (frame_ctr),
      .mask      (mask_q),
      .byte_base (base_q),
      .byte_addr (addr_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_valid <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         rd_slot   <= '0;
      end else begin
         mem_valid <= accept;
         mem_we    <= accept & req_wr;
         if (accept) begin
            mem_addr <= addr_d;
            rd_slot  <= slot_d;
         end
      end
   end
endmodule

// File: rtl/rbag_chk.sv
module rbag_chk #(
   parameter int MASK_W = 16,
   parameter int ADDR_W = 21,
   parameter int STEP_W = 7,
   parameter int SLOT_W = 2,
   localparam int CNT_W = MASK_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_end,
   input logic [STEP_W-1:0] step_idx,
   input logic              req_rd,
   input logic              req_wr,
   input logic              mem_valid,
   input logic              mem_we,
   input logic [SLOT_W-1:0] rd_slot,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [CNT_W-1:0]  frame_ctr,
   input logic [MASK_W-1:0] mask_q
);
   p_odd_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> $past(step_idx[0]));

   p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !((req_rd | req_wr) & step_idx[0]) |=> $stable(mem_addr));

   p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !((req_rd | req_wr) & step_idx[0]) |=> !mem_valid);

   p_we_in_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_valid);

   p_slot_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (rd_slot == SLOT_W'($past(step_idx[SLOT_W-1:0]) + SLOT_W'(2))));

   p_ctr_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ctr != '0);

   p_ctr_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && frame_ctr != CNT_W'(1)) |=> (frame_ctr == CNT_W'($past(frame_ctr) - CNT_W'(1))));

   p_ctr_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && frame_ctr == CNT_W'(1)) |=> (frame_ctr == CNT_W'(CNT_W'($past(mask_q)) + CNT_W'(1))));

   p_ctr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(frame_ctr));
endmodule

bind rbag_top rbag_chk #(
   .MASK_W (MASK_W),
   .ADDR_W (ADDR_W),
   .STEP_W (STEP_W),
   .SLOT_W (SLOT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frame_end (frame_end),
   .step_idx  (step_idx),
   .req_rd    (req_rd),
   .req_wr    (req_wr),
   .mem_valid (mem_valid),
   .mem_we    (mem_we),
   .rd_slot   (rd_slot),
   .mem_addr  (mem_addr),
   .frame_ctr (frame_ctr),
   .mask_q    (mask_q)
);

// File: tb/tb_rbag_top.sv
`timescale 1ns/1ps
module tb_rbag_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [15:0] cfg_mask = '0;
   logic [20:0] cfg_base = '0;
   logic        frame_end = 1'b0;
   logic [6:0]  step_idx = '0;
   logic        req_rd = 1'b0;
   logic        req_wr = 1'b0;
   logic [15:0] base_word = '0;
   logic [15:0] adrs_val = '0;
   logic        add_adrs = 1'b0;
   logic        next_word = 1'b0;
   logic        table_mode = 1'b0;
   logic [20:0] mem_addr;
   logic        mem_valid;
   logic        mem_we;
   logic [1:0]  rd_slot;
   logic [16:0] frame_ctr;

   int checks = 0;
   int errors = 0;

   // Model state
   logic [15:0] m_mask = 16'h7FFF;
   logic [20:0] m_base = '0;
   logic [16:0] m_ctr  = 17'd1;
   logic [20:0] m_addr = '0;
   logic        m_valid = 1'b0;
   logic        m_we = 1'b0;
   logic [1:0]  m_slot = '0;

   always #4 clk = ~clk;

   rbag_top dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mask(cfg_mask),
      .cfg_base(cfg_base), .frame_end(frame_end), .step_idx(step_idx),
      .req_rd(req_rd), .req_wr(req_wr), .base_word(base_word),
      .adrs_val(adrs_val), .add_adrs(add_adrs), .next_word(next_word),
      .table_mode(table_mode), .mem_addr(mem_addr), .mem_valid(mem_valid),
      .mem_we(mem_we), .rd_slot(rd_slot), .frame_ctr(frame_ctr)
   );

   function automatic logic [20:0] f_addr(logic [15:0] b, logic [15:0] a, logic ad,
                                          logic nx, logic tb, logic [16:0] c,
                                          logic [15:0] m, logic [20:0] rb);
      logic [31:0] w;
      w = 32'(b) + (ad ? 32'(a[11:0]) : 32'd0) + 32'(nx);
      if (tb) w = w & 32'h0000_FFFF;
      else    w = (w + 32'(c)) & 32'(m);
      w = (w << 1) + 32'(rb);
      return w[20:0];
   endfunction

   task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
      end
   endtask

   // Inputs are already driven; advance one cycle and compare all outputs.
   task automatic cycle(string tag);
      logic acc;
      acc = (req_rd | req_wr) & step_idx[0];
      m_valid = acc;
      m_we = acc & req_wr;
      if (acc) begin
         m_addr = f_addr(base_word, adrs_val, add_adrs, next_word, table_mode,
                         m_ctr, m_mask, m_base);
         m_slot = step_idx[1:0] + 2'd2;
      end
      if (frame_end) m_ctr = (m_ctr == 17'd1) ? 17'(m_mask) + 17'd1 : m_ctr - 17'd1;
      if (cfg_load) begin
         m_mask = cfg_mask;
         m_base = cfg_base;
      end
      @(posedge clk);
      @(negedge clk);
      chk({tag, " R5 R6"}, "mem_valid", 32'(mem_valid), 32'(m_valid));
      chk({tag, " R6"}, "mem_we", 32'(mem_we), 32'(m_we));
      chk({tag, " R1 R2 R3 R4 R5"}, "mem_addr", 32'(mem_addr), 32'(m_addr));
      chk({tag, " R8 R10"}, "frame_ctr", 32'(frame_ctr), 32'(m_ctr));
      if (m_valid) chk({tag, " R7"}, "rd_slot", 32'(rd_slot), 32'(m_slot));
   endtask

   task automatic idle();
      cfg_load = 0; frame_end = 0; req_rd = 0; req_wr = 0;
      add_adrs = 0; next_word = 0; table_mode = 0;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk("R9", "frame_ctr", 32'(frame_ctr), 32'd1);
      chk("R9", "mem_valid", 32'(mem_valid), 32'd0);
      chk("R9", "mem_we", 32'(mem_we), 32'd0);
      chk("R9", "mem_addr", 32'(mem_addr), 32'd0);

      // R2 with reset mask: 0x7FFF + count 1 wraps to word 0
      step_idx = 7'd1; req_rd = 1; base_word = 16'h7FFF;
      cycle("R2 R9 wrap");
      chk("R2", "wrapped addr", 32'(mem_addr), 32'd0);

      // R1: offset top bits ignored, plus one
      idle(); step_idx = 7'd3; req_rd = 1; base_word = 16'h0100;
      adrs_val = 16'hF123; add_adrs = 1; next_word = 1;
      cycle("R1 offset");
      chk("R1", "offset addr", 32'(mem_addr), 32'((16'h0100 + 16'h123 + 1 + 1) << 1));

      // R5: even step request ignored, address held
      idle(); step_idx = 7'd4; req_wr = 1; base_word = 16'h1234;
      cycle("R5 even");
      chk("R5", "held addr", 32'(mem_addr), 32'((16'h0100 + 16'h123 + 2) << 1));

      // R6: both read and write gives a write; R7 slot wraps 127+2 -> 1
      idle(); step_idx = 7'd127; req_rd = 1; req_wr = 1; base_word = 16'h0010;
      cycle("R6 R7 both");
      chk("R6", "write wins", 32'(mem_we), 32'd1);
      chk("R7", "slot wrap", 32'(rd_slot), 32'd1);

      // R8: count 1 at frame end reloads with mask+1
      idle(); frame_end = 1;
      cycle("R8 reload");
      chk("R8", "reload", 32'(frame_ctr), 32'h8000);
      idle(); frame_end = 1;
      cycle("R8 down");
      chk("R8", "down", 32'(frame_ctr), 32'h7FFF);

      // R11 + R10: load and frame end together with a request use old state
      idle(); cfg_load = 1; cfg_mask = 16'h00FF; cfg_base = 21'h001000;
      frame_end = 1; step_idx = 7'd5; req_rd = 1; base_word = 16'h0001;
      cycle("R11 same cycle");
      chk("R11", "old state addr", 32'(mem_addr), 32'(((16'h0001 + 17'h7FFF) & 17'h7FFF) << 1));
      chk("R10", "ctr after load", 32'(frame_ctr), 32'h7FFE);

      // R3 and R4: table wrap at 16 bits, byte base near top wraps 21 bits
      idle(); cfg_load = 1; cfg_mask = 16'h00FF; cfg_base = 21'h1FFFFE;
      cycle("R10 load");
      idle(); step_idx = 7'd9; req_rd = 1; table_mode = 1; base_word = 16'hFFFF; next_word = 1;
      cycle("R3 table");
      chk("R3", "table wrap", 32'(mem_addr), 32'h1FFFFE);
      idle(); step_idx = 7'd11; req_rd = 1; table_mode = 1; base_word = 16'h0002;
      cycle("R4 trunc");
      chk("R4", "21-bit trunc", 32'(mem_addr), 32'h000002);

      // Random stimulus
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 3000; i++) begin
         int sel;
         idle();
         if (($urandom % 24) == 0) begin
            sel = $urandom % 6;
            case (sel)
               0: cfg_mask = 16'h7FFF;
               1: cfg_mask = 16'h00FF;
               2: cfg_mask = 16'h0FFF;
               3: cfg_mask = 16'h0007;
               4: cfg_mask = 16'hFFFF;
               default: cfg_mask = 16'($urandom);
            endcase
            cfg_base = 21'($urandom);
            cfg_load = 1;
         end
         frame_end  = (($urandom % 4) == 0);
         step_idx   = 7'($urandom);
         req_rd     = 1'($urandom);
         req_wr     = 1'($urandom);
         base_word  = 16'($urandom);
         adrs_val   = 16'($urandom);
         add_adrs   = 1'($urandom);
         next_word  = 1'($urandom);
         table_mode = (($urandom % 3) == 0);
         cycle("rand");
      end
      summary();
   end
endmodule